// File: doc/BRIEF.md
# Serial Audio Link Frame Controller

This block is the controller end of a five-wire time-division audio link. The codec drives the bit clock, and the block runs entirely on it. The block counts 256 bit periods per frame and drives the frame sync. It serialises an outgoing frame made of a 16-bit tag word and twelve 20-bit slots. In the same frame it deserialises the incoming frame. Only slots 1 to 4 carry content: a register address, register data, and the left and right PCM samples. Slots 5 to 12 are sent as zeros and ignored on receive.

On the local side there are three interfaces. Playback sample pairs enter through a valid/ready port. A register access enters through a second valid/ready port and completes with a done pulse. Record samples leave as plain data outputs with a one-cycle valid flag per channel. The frame clock cannot be stalled, so both ready signals open only at the frame boundary. A producer keeps valid and its data steady until it sees ready high in the same cycle. The record outputs have no ready, because the link cannot wait, and a consumer must take each flagged sample in the cycle its flag is high.

Top module: `aclink_frame_ctrl`

## Requirements
- R1: Every frame lasts exactly 256 bit clocks. `sync` is high for the first 16 bit times of each frame on the line (the tag phase) and low for the remaining 240.
- R2: Outgoing bits are sent most-significant first: the 16-bit tag, then slots 1 to 12 of 20 bits each. Tag bit 15 is set when any slot is valid, and tag bits 14, 13, 12 and 11 mark slots 1, 2, 3 and 4. Tag bits 10 to 0 and slots 5 to 12 are always zero.
- R3: A register access places the read flag (1 = read, 0 = write) in slot 1 bit 19 and the 7-bit index in slot 1 bits 18:12. All other slot 1 bits are zero. A write also places the 16-bit data in slot 2 bits 19:4 and sets the slot 2 tag. A read leaves slot 2 and its tag at zero.
- R4: `pb_ready` is high for exactly one bit clock per frame, two bit clocks before `sync` rises. A pair taken then is sent in the next frame, left-justified in slots 3 and 4 with the low 4 bits zero and both tags set. If no pair is taken, those slots and tags are zero.
- R5: `reg_req_ready` is high only in the boundary cycle, and only while no access is outstanding.
- R6: An accepted write is sent in the next frame. It ends with a one-cycle `reg_done` within 300 bit clocks of acceptance.
- R7: An accepted read ends with a one-cycle `reg_done`. This happens when an incoming frame has tag bits 15 and 14 set and slot 1 bits 18:12 equal to the requested index. `reg_rdata` then holds incoming slot 2 bits 19:4. A status slot with any other index is ignored.
- R8: Incoming bits are captured on the falling bit-clock edge.
- R9: For each incoming frame with tag bits 15 and 12 set, `rec_left_vld` pulses once with `rec_left` equal to slot 3 bits 19:4. Tag bit 11 does the same for slot 4 on the right channel. There is no pulse when the tag bit is clear.
- R10: While reset is held, `sync`, `sdata_out`, both ready outputs, `reg_done` and both record valid flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock driven by the codec |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | output | 1 | Frame sync, high during the tag phase |
| sdata_out | output | 1 | Serial data to the codec |
| sdata_in | input | 1 | Serial data from the codec |
| pb_valid | input | 1 | Playback pair valid |
| pb_ready | output | 1 | Playback pair taken at this edge if valid |
| pb_left | input | 16 | Left playback sample |
| pb_right | input | 16 | Right playback sample |
| reg_req_valid | input | 1 | Register access request valid |
| reg_req_ready | output | 1 | Request accepted at this edge if valid |
| reg_req_rd | input | 1 | 1 = read, 0 = write |
| reg_req_idx | input | 7 | Register index |
| reg_req_wdata | input | 16 | Write data |
| reg_done | output | 1 | One-cycle completion pulse |
| reg_rdata | output | 16 | Read data, valid with `reg_done` of a read |
| rec_left | output | 16 | Left record sample |
| rec_right | output | 16 | Right record sample |
| rec_left_vld | output | 1 | One-cycle flag for `rec_left` |
| rec_right_vld | output | 1 | One-cycle flag for `rec_right` |

## Verification
A slip in the bit or slot counters shows on the line within one frame. The sync edge, the 256-clock period, the tag bits and the slot positions are all compared bit by bit against a behavioural codec, so a fault is caught inside 256 clocks. A stuck access state shows as a ready that never reopens, or as a done that is missing or arrives twice, within one or two frames. A receive-side fault appears as a wrong or missing record sample at the next slot 4 boundary. The codec model changes its data bit on both sides of the falling edge, so capture on the wrong edge corrupts every sample it returns.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int TAG_BITS   = 16;
  localparam int SLOT_BITS  = 20;
  localparam int NUM_SLOTS  = 12;
  localparam int SMP_BITS   = 16;
  localparam int IDX_BITS   = 7;
  localparam int USED_SLOTS = 4;
  localparam int PAD_BITS   = SLOT_BITS - SMP_BITS;
  localparam int ADDR_LSB   = SLOT_BITS - 1 - IDX_BITS;
  localparam int TAG_KEEP   = 1 + USED_SLOTS;
  localparam int SLOTNO_W   = $clog2(NUM_SLOTS + 1);
  localparam int BITNO_W    = $clog2(SLOT_BITS);

  typedef enum logic [1:0] {ACC_IDLE, ACC_WR, ACC_RD} acc_state_e;
endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer
  import aclink_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  output logic [SLOTNO_W-1:0] slot_no,
  output logic [BITNO_W-1:0]  bit_no,
  output logic                frame_last
);
  assign frame_last = (slot_no == SLOTNO_W'(NUM_SLOTS)) && (bit_no == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_no <= '0;
      bit_no  <= BITNO_W'(TAG_BITS - 1);
    end else if (bit_no == '0) begin
      if (frame_last) begin
        slot_no <= '0;
        bit_no  <= BITNO_W'(TAG_BITS - 1);
      end else begin
        slot_no <= slot_no + 1'b1;
        bit_no  <= BITNO_W'(SLOT_BITS - 1);
      end
    end else begin
      bit_no <= bit_no - 1'b1;
    end
  end

  // independent gap counter guarding the frame length
  logic [7:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap_q <= '0;
    else if (frame_last) gap_q <= '0;
    else                 gap_q <= gap_q + 1'b1;
  end

  p_frame_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |-> (gap_q == 8'd255));
  p_no_early_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q != 8'd255) |-> !frame_last);
endmodule

// File: rtl/aclink_tx.sv
module aclink_tx
  import aclink_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SLOTNO_W-1:0] slot_no,
  input  logic [BITNO_W-1:0]  bit_no,
  input  logic                frame_last,
  input  logic                pb_take,
  input  logic [SMP_BITS-1:0] pb_l,
  input  logic [SMP_BITS-1:0] pb_r,
  input  logic                acc_take,
  input  logic                acc_rd,
  input  logic [IDX_BITS-1:0] acc_idx,
  input  logic [SMP_BITS-1:0] acc_wdata,
  output logic                sync,
  output logic                sdata_out
);
  logic [TAG_BITS-1:0]  tag_q;
  logic [SLOT_BITS-1:0] word_q [USED_SLOTS];
  logic [SLOT_BITS-1:0] word_d [USED_SLOTS];
  logic [TAG_KEEP-1:0]  flags_d;

  always_comb begin
    word_d[0] = acc_take ? {acc_rd, acc_idx, {ADDR_LSB{1'b0}}} : '0;
    word_d[1] = (acc_take && !acc_rd) ? {acc_wdata, {PAD_BITS{1'b0}}} : '0;
    word_d[2] = pb_take ? {pb_l, {PAD_BITS{1'b0}}} : '0;
    word_d[3] = pb_take ? {pb_r, {PAD_BITS{1'b0}}} : '0;
    flags_d[TAG_KEEP-2:0] = {acc_take, acc_take && !acc_rd, pb_take, pb_take};
    flags_d[TAG_KEEP-1]   = |flags_d[TAG_KEEP-2:0];
  end

  for (genvar s = 0; s < USED_SLOTS; s++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          word_q[s] <= '0;
      else if (frame_last) word_q[s] <= word_d[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tag_q <= '0;
    else if (frame_last) tag_q <= {flags_d, {(TAG_BITS-TAG_KEEP){1'b0}}};
  end

  logic [1:0] widx;
  logic       nxt_bit;
  always_comb begin
    widx    = slot_no[1:0] - 2'd1;
    nxt_bit = 1'b0;
    if (slot_no == '0)
      nxt_bit = tag_q[bit_no[3:0]];
    else if (slot_no <= SLOTNO_W'(USED_SLOTS))
      nxt_bit = word_q[widx][bit_no];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync      <= 1'b0;
      sdata_out <= 1'b0;
    end else begin
      sync      <= (slot_no == '0);
      sdata_out <= nxt_bit;
    end
  end

  p_quiet_slots_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_no > SLOTNO_W'(USED_SLOTS)) |=> !sdata_out);
endmodule

// File: rtl/aclink_rx.sv
module aclink_rx
  import aclink_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SLOTNO_W-1:0] slot_no,
  input  logic [BITNO_W-1:0]  bit_no,
  input  logic                sdata_in,
  output logic                st_strobe,
  output logic                st_vld,
  output logic [IDX_BITS-1:0] st_idx,
  output logic [SMP_BITS-1:0] st_data,
  output logic [SMP_BITS-1:0] rec_l,
  output logic [SMP_BITS-1:0] rec_r,
  output logic                rec_l_vld,
  output logic                rec_r_vld
);
  localparam int NDATA = USED_SLOTS - 1;

  // position of the bit currently on the line
  logic [SLOTNO_W-1:0] rx_slot;
  logic [BITNO_W-1:0]  rx_bit;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_slot <= '0;
      rx_bit  <= BITNO_W'(TAG_BITS - 1);
    end else begin
      rx_slot <= slot_no;
      rx_bit  <= bit_no;
    end
  end

  logic [TAG_KEEP-1:0] tag_sh;
  logic [IDX_BITS-1:0] idx_sh;
  logic [SMP_BITS-1:0] dat_sh [NDATA];

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_sh <= '0;
      idx_sh <= '0;
    end else begin
      if (rx_slot == '0 && rx_bit >= BITNO_W'(TAG_BITS - TAG_KEEP))
        tag_sh <= {tag_sh[TAG_KEEP-2:0], sdata_in};
      if (rx_slot == SLOTNO_W'(1) && rx_bit <= BITNO_W'(SLOT_BITS - 2)
          && rx_bit >= BITNO_W'(ADDR_LSB))
        idx_sh <= {idx_sh[IDX_BITS-2:0], sdata_in};
    end
  end

  for (genvar s = 0; s < NDATA; s++) begin : g_data
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)
        dat_sh[s] <= '0;
      else if (rx_slot == SLOTNO_W'(s + 2) && rx_bit >= BITNO_W'(PAD_BITS))
        dat_sh[s] <= {dat_sh[s][SMP_BITS-2:0], sdata_in};
    end
  end

  assign st_strobe = (rx_slot == SLOTNO_W'(USED_SLOTS)) && (rx_bit == '0);
  assign st_vld    = tag_sh[TAG_KEEP-1] && tag_sh[TAG_KEEP-2];
  assign st_idx    = idx_sh;
  assign st_data   = dat_sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_l     <= '0;
      rec_r     <= '0;
      rec_l_vld <= 1'b0;
      rec_r_vld <= 1'b0;
    end else begin
      rec_l_vld <= st_strobe && tag_sh[TAG_KEEP-1] && tag_sh[1];
      rec_r_vld <= st_strobe && tag_sh[TAG_KEEP-1] && tag_sh[0];
      if (st_strobe) begin
        rec_l <= dat_sh[1];
        rec_r <= dat_sh[2];
      end
    end
  end

  p_rec_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rec_l_vld |=> !rec_l_vld);
endmodule

// File: rtl/aclink_access.sv
module aclink_access
  import aclink_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_last,
  input  logic                req_valid,
  input  logic                req_rd,
  input  logic [IDX_BITS-1:0] req_idx,
  output logic                req_ready,
  output logic                take,
  input  logic                st_strobe,
  input  logic                st_vld,
  input  logic [IDX_BITS-1:0] st_idx,
  input  logic [SMP_BITS-1:0] st_data,
  output logic                done,
  output logic [SMP_BITS-1:0] rdata
);
  acc_state_e          state_q;
  logic [IDX_BITS-1:0] idx_q;

  assign req_ready = frame_last && (state_q == ACC_IDLE);
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACC_IDLE;
      idx_q   <= '0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ACC_IDLE: if (take) begin
          state_q <= req_rd ? ACC_RD : ACC_WR;
          idx_q   <= req_idx;
        end
        ACC_WR: if (frame_last) begin
          done    <= 1'b1;
          state_q <= ACC_IDLE;
        end
        ACC_RD: if (st_strobe && st_vld && st_idx == idx_q) begin
          done    <= 1'b1;
          rdata   <= st_data;
          state_q <= ACC_IDLE;
        end
        default: state_q <= ACC_IDLE;
      endcase
    end
  end

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !req_ready);
endmodule

// File: rtl/aclink_frame_ctrl.sv
module aclink_frame_ctrl
  import aclink_pkg::*;
(
  input  logic                bit_clk,
  input  logic                rst_n,
  output logic                sync,
  output logic                sdata_out,
  input  logic                sdata_in,
  input  logic                pb_valid,
  output logic                pb_ready,
  input  logic [SMP_BITS-1:0] pb_left,
  input  logic [SMP_BITS-1:0] pb_right,
  input  logic                reg_req_valid,
  output logic                reg_req_ready,
  input  logic                reg_req_rd,
  input  logic [IDX_BITS-1:0] reg_req_idx,
  input  logic [SMP_BITS-1:0] reg_req_wdata,
  output logic                reg_done,
  output logic [SMP_BITS-1:0] reg_rdata,
  output logic [SMP_BITS-1:0] rec_left,
  output logic [SMP_BITS-1:0] rec_right,
  output logic                rec_left_vld,
  output logic                rec_right_vld
);
  logic [SLOTNO_W-1:0] slot_no;
  logic [BITNO_W-1:0]  bit_no;
  logic                frame_last;
  logic                acc_take;
  logic                st_strobe, st_vld;
  logic [IDX_BITS-1:0] st_idx;
  logic [SMP_BITS-1:0] st_data;

  assign pb_ready = frame_last;

  aclink_frame_timer u_timer (
    .clk(bit_clk), .rst_n(rst_n), .slot_no(slot_no), .bit_no(bit_no),
    .frame_last(frame_last));

  aclink_access u_access (
    .clk(bit_clk), .rst_n(rst_n), .frame_last(frame_last),
    .req_valid(reg_req_valid), .req_rd(reg_req_rd), .req_idx(reg_req_idx),
    .req_ready(reg_req_ready), .take(acc_take),
    .st_strobe(st_strobe), .st_vld(st_vld), .st_idx(st_idx), .st_data(st_data),
    .done(reg_done), .rdata(reg_rdata));

  aclink_tx u_tx (
    .clk(bit_clk), .rst_n(rst_n), .slot_no(slot_no), .bit_no(bit_no),
    .frame_last(frame_last), .pb_take(pb_valid && pb_ready),
    .pb_l(pb_left), .pb_r(pb_right), .acc_take(acc_take), .acc_rd(reg_req_rd),
    .acc_idx(reg_req_idx), .acc_wdata(reg_req_wdata),
    .sync(sync), .sdata_out(sdata_out));

  aclink_rx u_rx (
    .clk(bit_clk), .rst_n(rst_n), .slot_no(slot_no), .bit_no(bit_no),
    .sdata_in(sdata_in), .st_strobe(st_strobe), .st_vld(st_vld),
    .st_idx(st_idx), .st_data(st_data), .rec_l(rec_left), .rec_r(rec_right),
    .rec_l_vld(rec_left_vld), .rec_r_vld(rec_right_vld));

  p_ready_sync_r4: assert property (@(posedge bit_clk) disable iff (!rst_n)
    pb_ready |=> !sync ##1 sync);
endmodule

// File: tb/test_aclink_frame_ctrl.sv
`timescale 1ns/1ps
module test_aclink_frame_ctrl;
  logic bit_clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync, sdata_out;
  logic sdata_in = 1'b0;
  logic pb_valid = 1'b0, pb_ready;
  logic [15:0] pb_left = '0, pb_right = '0;
  logic reg_req_valid = 1'b0, reg_req_ready, reg_req_rd = 1'b0;
  logic [6:0] reg_req_idx = '0;
  logic [15:0] reg_req_wdata = '0;
  logic reg_done;
  logic [15:0] reg_rdata, rec_left, rec_right;
  logic rec_left_vld, rec_right_vld;

  always #2.5 bit_clk = ~bit_clk;

  aclink_frame_ctrl i_aclink_frame_ctrl (
    .bit_clk(bit_clk), .rst_n(rst_n), .sync(sync), .sdata_out(sdata_out),
    .sdata_in(sdata_in), .pb_valid(pb_valid), .pb_ready(pb_ready),
    .pb_left(pb_left), .pb_right(pb_right), .reg_req_valid(reg_req_valid),
    .reg_req_ready(reg_req_ready), .reg_req_rd(reg_req_rd),
    .reg_req_idx(reg_req_idx), .reg_req_wdata(reg_req_wdata),
    .reg_done(reg_done), .reg_rdata(reg_rdata), .rec_left(rec_left),
    .rec_right(rec_right), .rec_left_vld(rec_left_vld),
    .rec_right_vld(rec_right_vld));

  int n_tests = 0, n_fail = 0;
  task automatic check(input bit ok, input string msg);
    n_tests++;
    if (!ok) begin n_fail++; $display("FAIL %s", msg); end
  endtask

  function automatic logic [15:0] init_val(input int i);
    return 16'(i * 16'h0101) ^ 16'h5A00;
  endfunction

  // ---------------- reference / codec model state ----------------
  logic [255:0] exp_cur = '0, exp_next = '0, cap = '0;
  logic [255:0] in_cur = '0, in_next = '0;
  logic [15:0]  regfile [128];
  logic [15:0]  q_l [$];
  logic [15:0]  q_r [$];
  int  pos = 0;
  bit  started = 0;
  bit  f_sync_bad, f_data_bad, f_rdy_bad;
  int  bad_pos;
  logic act_bit, exp_bit;
  bit  busy = 0, busy_rd = 0;
  bit  pb_acc = 0, req_acc = 0, done_flag = 0;
  logic [15:0] exp_rdata = '0;
  bit  pend_rsp = 0, bad_once = 0;
  logic [6:0] rsp_idx = '0;
  int  cyc = 0;

  initial for (int i = 0; i < 128; i++) regfile[i] = init_val(i);

  // codec-side input driver: true bit only around the falling edge (R8)
  int in_pos = 0;
  bit in_started = 0;
  always begin
    @(posedge bit_clk);
    #0.5;
    if (!rst_n) begin
      in_started = 0; sdata_in = 1'b0;
    end else begin
      logic b;
      if (in_started) in_pos = (in_pos + 1) % 256;
      else if (sync) begin in_started = 1; in_pos = 0; end
      if (in_started && in_pos == 0) in_cur = in_next;
      b = in_started ? in_cur[255 - in_pos] : 1'b0;
      sdata_in = ~b;
      #1.5 sdata_in = b;
      #1.0 sdata_in = ~b;
    end
  end

  task automatic codec_frame();
    logic [15:0] t; logic [19:0] w1, w2, w3, w4;
    logic [15:0] it; logic [19:0] i1, i2, i3, i4;
    t = cap[255:240]; w1 = cap[239:220]; w2 = cap[219:200];
    w3 = cap[199:180]; w4 = cap[179:160];
    it = '0; i1 = '0; i2 = '0; i3 = '0; i4 = '0;
    if (t[15] && t[12]) begin i3 = w3; it[12] = 1'b1; q_l.push_back(w3[19:4]); end
    if (t[15] && t[11]) begin i4 = w4; it[11] = 1'b1; q_r.push_back(w4[19:4]); end
    if (t[15] && t[14] && t[13] && !w1[19]) regfile[w1[18:12]] = w2[19:4];
    if (t[15] && t[14] && w1[19]) begin pend_rsp = 1; rsp_idx = w1[18:12]; end
    if (pend_rsp) begin
      it[14] = 1'b1; it[13] = 1'b1;
      if (bad_once) begin
        i1 = {1'b0, rsp_idx ^ 7'h01, 12'h000};
        i2 = {~regfile[rsp_idx], 4'h0};
        bad_once = 0;
      end else begin
        i1 = {1'b0, rsp_idx, 12'h000};
        i2 = {regfile[rsp_idx], 4'h0};
        pend_rsp = 0;
      end
    end
    if (it != '0) it[15] = 1'b1;
    in_next = {it, i1, i2, i3, i4, 160'b0};
  endtask

  // line monitor, sampled on the falling edge
  always @(negedge bit_clk) begin
    if (!rst_n) begin
      started = 0;
    end else begin
      cyc++;
      if (started) pos = (pos + 1) % 256;
      else if (sync) begin started = 1; pos = 0; end
      if (started) begin
        if (pos == 0) begin
          exp_cur = exp_next; f_sync_bad = 0; f_data_bad = 0; f_rdy_bad = 0;
        end
        if (sync !== (pos < 16)) f_sync_bad = 1;
        if (sdata_out !== exp_cur[255 - pos] && !f_data_bad) begin
          f_data_bad = 1; bad_pos = pos; act_bit = sdata_out; exp_bit = exp_cur[255 - pos];
        end
        cap[255 - pos] = sdata_out;
        if (pb_ready !== (pos == 254) || reg_req_ready !== (pos == 254 && !busy))
          f_rdy_bad = 1;
        if (pos == 254) begin
          logic [19:0] w1, w2, w3, w4; logic [15:0] t;
          bit acc, pbt;
          pbt = pb_valid && pb_ready;
          acc = reg_req_valid && reg_req_ready;
          w1 = acc ? {reg_req_rd, reg_req_idx, 12'h000} : '0;
          w2 = (acc && !reg_req_rd) ? {reg_req_wdata, 4'h0} : '0;
          w3 = pbt ? {pb_left, 4'h0} : '0;
          w4 = pbt ? {pb_right, 4'h0} : '0;
          t = {(acc || pbt), acc, acc && !reg_req_rd, pbt, pbt, 11'b0};
          exp_next = {t, w1, w2, w3, w4, 160'b0};
          if (pbt) pb_acc = 1;
          if (acc) begin req_acc = 1; busy = 1; busy_rd = reg_req_rd; end
        end
        if (pos == 255) begin
          check(!f_sync_bad, $sformatf("R1 sync width/period wrong in frame (exp high for 16 of 256)"));
          check(!f_data_bad, $sformatf("R2 R3 R4 frame bit %0d act=%0b exp=%0b", bad_pos, act_bit, exp_bit));
          check(!f_rdy_bad, "R4 R5 ready timing act=wrong cycle exp=only line bit 254");
          codec_frame();
        end
      end
      if (reg_done) begin
        if (!busy) check(0, "R6 reg_done act=1 exp=0 (nothing outstanding)");
        else if (busy_rd)
          check(reg_rdata == exp_rdata,
                $sformatf("R7 read data act=%h exp=%h", reg_rdata, exp_rdata));
        else check(1, "R6 write done");
        busy = 0; done_flag = 1;
      end
      if (rec_left_vld) begin
        if (q_l.size() == 0) check(0, $sformatf("R9 left pulse act=%h exp=none", rec_left));
        else begin
          logic [15:0] e; e = q_l.pop_front();
          check(rec_left == e, $sformatf("R8 R9 left act=%h exp=%h", rec_left, e));
        end
      end
      if (rec_right_vld) begin
        if (q_r.size() == 0) check(0, $sformatf("R9 right pulse act=%h exp=none", rec_right));
        else begin
          logic [15:0] e; e = q_r.pop_front();
          check(rec_right == e, $sformatf("R8 R9 right act=%h exp=%h", rec_right, e));
        end
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge bit_clk) begin
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=%0d cycles exp=<150000", cyc);
      finish_run();
    end
  end

  task automatic send_pair(input logic [15:0] l, input logic [15:0] r);
    @(posedge bit_clk); #1;
    pb_valid = 1; pb_left = l; pb_right = r; pb_acc = 0;
    while (!pb_acc) @(posedge bit_clk);
    #1 pb_valid = 0;
  endtask

  task automatic reg_op(input bit rd, input logic [6:0] idx,
                        input logic [15:0] wd, input logic [15:0] expv);
    int t;
    @(posedge bit_clk); #1;
    reg_req_valid = 1; reg_req_rd = rd; reg_req_idx = idx; reg_req_wdata = wd;
    req_acc = 0; done_flag = 0; exp_rdata = expv;
    while (!req_acc) @(posedge bit_clk);
    #1 reg_req_valid = 0;
    t = 0;
    while (!done_flag && t < 1200) begin @(posedge bit_clk); t++; end
    check(done_flag, $sformatf("R6 R7 done act=missing exp=pulse idx=%h", idx));
    if (!rd) check(t <= 300, $sformatf("R6 write latency act=%0d exp<=300", t));
  endtask

  initial begin
    repeat (3) @(negedge bit_clk);
    check(!sync && !sdata_out && !pb_ready && !reg_req_ready && !reg_done
          && !rec_left_vld && !rec_right_vld,
          $sformatf("R10 reset outputs act=%b%b%b%b%b%b%b exp=0000000", sync, sdata_out,
                    pb_ready, reg_req_ready, reg_done, rec_left_vld, rec_right_vld));
    @(posedge bit_clk); #1 rst_n = 1;
    repeat (600) @(posedge bit_clk);          // idle frames: all-zero tag (R2)
    fork
      begin
        send_pair(16'h1234, 16'hABCD);
        send_pair(16'hFFFF, 16'h0001);        // back-to-back frames
        repeat (700) @(posedge bit_clk);      // gap: tags 12/11 clear (R4)
        send_pair(16'h8000, 16'h7FFF);
        send_pair(16'h0000, 16'hFFFF);
      end
      begin
        reg_op(0, 7'h02, 16'h8A5C, 16'h0);    // R3 write frame
        reg_op(1, 7'h02, 16'h0, 16'h8A5C);    // R3 read frame, R7
        reg_op(0, 7'h7F, 16'hFFFF, 16'h0);
        reg_op(1, 7'h7F, 16'h0, 16'hFFFF);
      end
    join
    bad_once = 1;                              // R7 wrong index ignored
    reg_op(1, 7'h02, 16'h0, 16'h8A5C);
    reg_op(1, 7'h10, 16'h0, init_val(16));
    repeat (900) @(posedge bit_clk);
    check(q_l.size() == 0 && q_r.size() == 0,
          $sformatf("R9 missing record pulses act=%0d/%0d exp=0/0", q_l.size(), q_r.size()));
    finish_run();
  end
endmodule